// File: doc/BRIEF.md
# Protection Register Unlock Sequencer

This block owns the protection register of a small serial memory. The register combines two volatile permission flags, a write latch and a register-write latch, with three retained bits: a protect-enable bit and a two-bit lock selector. The sequencer receives register writes that the bus engine has already decoded (address, data byte, strobe), the bus start and stop events, and a hardware lock pin.

The retained bits change only at the end of a three-stage sequence. First the write latch is set. Then the register-write latch is set. Finally a commit byte is sent and closed by a stop condition. The commit is refused while the pin and the protect-enable bit are both high. A start condition that arrives before the stop cancels the commit. A busy window of a set number of cycles stands in for the nonvolatile programming time.

The lock selector maps to a protected region at the top of the array: nothing, the upper quarter, the upper half, or the whole array. Array write requests that fall inside that region are flagged as blocked.

Top module: `prot_reg_sequencer`

## Requirements
- R1: After reset the write latch and the register-write latch are 0, `busy` is 0, and protect-enable and the lock selector hold the value of parameter `INIT_NV` ({protect-enable, lock[1:0]}).
- R2: A register write to `REG_ADDR` while no latch other than the write latch is set acts on data bits [2:1] only. A value of 01 sets the write latch and 00 clears it. All other data bits are ignored. A write to any other address changes nothing.
- R3: Data bits [2:1] = 11 set the register-write latch only if the write latch is already 1. If the write latch is 1 from an earlier write, the sequence may start at this step.
- R4: With the register-write latch at 1, a commit byte (bits [2:1] = 01) followed by `bus_stop` raises `busy` on the next clock for exactly `NV_CYCLES` cycles. When `busy` falls, protect-enable, lock[1] and lock[0] take data bits 7, 4 and 3. The register-write latch then clears and the write latch stays 1, so the two latches never clear in the same write.
- R5: With the register-write latch at 1, a byte with bit 2 = 1, or with bits [2:1] = 00, changes nothing. The register stays at the register-write stage.
- R6: If `hw_lock_pin` and protect-enable are both 1 when the commit byte arrives, the commit is refused. The next `bus_stop` returns the block to standby without `busy`, and the register is unchanged.
- R7: A `bus_start` after the commit byte and before its stop cancels the commit. The register-write latch stays 1, and the following stop returns to standby with no `busy`.
- R8: While a commit is pending, refused, cancelled or busy, further register writes are ignored. While `busy` is high, bus events are also ignored.
- R9: `arr_wr_block` is 1 exactly when `arr_wr_req` is 1 and the low `ARRAY_AW` bits of `arr_addr` fall in the locked region. Lock 00 protects none, 01 protects the top quarter (two top bits 11), 10 protects the top half (top bit 1), and 11 protects all.
- R10: `status` reports protect-enable at bit 7, lock[1] at bit 4, lock[0] at bit 3, the register-write latch at bit 2 and the write latch at bit 1. Bits 6, 5 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | ADDR_W | Register write address |
| reg_data | input | 8 | Register write data byte |
| bus_start | input | 1 | Start condition seen on the bus |
| bus_stop | input | 1 | Stop condition seen on the bus |
| hw_lock_pin | input | 1 | Hardware lock pin, active high |
| arr_wr_req | input | 1 | Array write request |
| arr_addr | input | ADDR_W | Array write address |
| arr_wr_block | output | 1 | Array write falls in the locked region |
| busy | output | 1 | Retained-bit write in progress |
| status | output | 8 | Protection register readback |

## Verification
Register writes, cancels and refusals show in `status` one clock after the strobe. The bench drives each strobe for one cycle from a falling edge and reads `status` at the next falling edge. `busy` rises one clock after the stop that closes a commit. The bench counts falling edges while `busy` is high and expects exactly `NV_CYCLES`; the retained bits are checked both in the middle of the busy window (still old) and after it (new). `arr_wr_block` is combinational, so the address sweep samples it 1 ns after each new address, without waiting for a clock edge.

// File: rtl/prot_reg_pkg.sv
`timescale 1ns/1ps
package prot_reg_pkg;

  localparam int unsigned REG_W       = 8;
  localparam int unsigned BIT_PROT    = 7;
  localparam int unsigned BIT_LOCK_HI = 4;
  localparam int unsigned BIT_LOCK_LO = 3;
  localparam int unsigned BIT_RWL     = 2;
  localparam int unsigned BIT_WL      = 1;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PEND  = 2'd1,
    SEQ_ABORT = 2'd2,
    SEQ_BUSY  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic       prot_en;
    logic [1:0] lock;
  } nv_bits_t;

  // Latch-control codes carried in data bits [2:1]
  localparam logic [1:0] CODE_CLR_WL = 2'b00;
  localparam logic [1:0] CODE_SET_WL = 2'b01;
  localparam logic [1:0] CODE_SET_RW = 2'b11;

  function automatic logic [REG_W-1:0] pack_status(nv_bits_t nv, logic rwl, logic wl);
    logic [REG_W-1:0] s;
    s              = '0;
    s[BIT_PROT]    = nv.prot_en;
    s[BIT_LOCK_HI] = nv.lock[1];
    s[BIT_LOCK_LO] = nv.lock[0];
    s[BIT_RWL]     = rwl;
    s[BIT_WL]      = wl;
    return s;
  endfunction

  // Region hit from the selector and the two top array address bits
  function automatic logic region_hit(logic [1:0] lock, logic [1:0] top2);
    case (lock)
      2'b00:   return 1'b0;
      2'b01:   return (top2 == 2'b11);
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/prot_busy_timer.sv
`timescale 1ns/1ps
module prot_busy_timer #(
  parameter int unsigned CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  assign done = act_q && (cnt_q == '0);

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      act_d  = 1'b1;
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (done) begin
      act_d  = 1'b0;
    end else if (act_q) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/prot_range_decode.sv
`timescale 1ns/1ps
module prot_range_decode
  import prot_reg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned ARRAY_AW = 13
) (
  input  logic [1:0]        lock,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  output logic              blocked
);
  localparam int unsigned TOP = ARRAY_AW - 1;

  logic [1:0] top2;

  generate
    if (ADDR_W > ARRAY_AW) begin : g_wide
      logic unused_hi_bits;
      assign unused_hi_bits = ^{addr[ADDR_W-1:ARRAY_AW], addr[TOP-2:0]};
    end else begin : g_narrow
      logic unused_lo_bits;
      assign unused_lo_bits = ^addr[TOP-2:0];
    end
  endgenerate

  assign top2    = addr[TOP -: 2];
  assign blocked = wr_req && region_hit(lock, top2);
endmodule

// File: rtl/prot_seq_fsm.sv
`timescale 1ns/1ps
module prot_seq_fsm
  import prot_reg_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = '1,
  parameter logic [2:0]      INIT_NV  = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_data,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              hw_lock_pin,
  input  logic              tmr_done,
  output logic              tmr_start,
  output nv_bits_t          nv,
  output logic              rwl,
  output logic              wl
);
  seq_state_e st_q, st_d;
  nv_bits_t   nv_q, nv_d, pend_q, pend_d;
  logic       wl_q, wl_d, rwl_q, rwl_d;
  logic       hit, reg_locked, pend_en, nv_en;
  logic [1:0] code;
  logic       unused_data_bits;

  assign unused_data_bits = ^{reg_data[6:5], reg_data[0]};
  assign hit        = reg_wr && (reg_addr == REG_ADDR);
  assign code       = reg_data[BIT_RWL:BIT_WL];
  assign reg_locked = hw_lock_pin && nv_q.prot_en;

  always_comb begin
    st_d      = st_q;
    wl_d      = wl_q;
    rwl_d     = rwl_q;
    nv_d      = nv_q;
    pend_d    = pend_q;
    pend_en   = 1'b0;
    nv_en     = 1'b0;
    tmr_start = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (hit) begin
          if (rwl_q) begin
            if (code == CODE_SET_WL) begin
              if (reg_locked) begin
                st_d = SEQ_ABORT;
              end else begin
                pend_d.prot_en = reg_data[BIT_PROT];
                pend_d.lock    = {reg_data[BIT_LOCK_HI], reg_data[BIT_LOCK_LO]};
                pend_en        = 1'b1;
                st_d           = SEQ_PEND;
              end
            end
          end else begin
            unique case (code)
              CODE_SET_WL: wl_d = 1'b1;
              CODE_CLR_WL: wl_d = 1'b0;
              CODE_SET_RW: if (wl_q) rwl_d = 1'b1;
              default: ;
            endcase
          end
        end
      end
      SEQ_PEND: begin
        if (bus_start) begin
          st_d = SEQ_ABORT;
        end else if (bus_stop) begin
          st_d      = SEQ_BUSY;
          tmr_start = 1'b1;
        end
      end
      SEQ_ABORT: begin
        if (bus_stop) st_d = SEQ_IDLE;
      end
      SEQ_BUSY: begin
        if (tmr_done) begin
          nv_d  = pend_q;
          nv_en = 1'b1;
          rwl_d = 1'b0;
          st_d  = SEQ_IDLE;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      wl_q   <= 1'b0;
      rwl_q  <= 1'b0;
      nv_q   <= nv_bits_t'(INIT_NV);
      pend_q <= nv_bits_t'(INIT_NV);
    end else begin
      st_q  <= st_d;
      wl_q  <= wl_d;
      rwl_q <= rwl_d;
      if (nv_en)   nv_q   <= nv_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign nv  = nv_q;
  assign rwl = rwl_q;
  assign wl  = wl_q;
endmodule

// File: rtl/prot_reg_sequencer.sv
`timescale 1ns/1ps
module prot_reg_sequencer
  import prot_reg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR  = '1,
  parameter int unsigned       ARRAY_AW  = 13,
  parameter int unsigned       NV_CYCLES = 20,
  parameter logic [2:0]        INIT_NV   = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_data,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              hw_lock_pin,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic              arr_wr_block,
  output logic              busy,
  output logic [7:0]        status
);
  nv_bits_t nv;
  logic     rwl, wl, tmr_start, tmr_done;

  prot_seq_fsm #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .INIT_NV  (INIT_NV)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_data    (reg_data),
    .bus_start   (bus_start),
    .bus_stop    (bus_stop),
    .hw_lock_pin (hw_lock_pin),
    .tmr_done    (tmr_done),
    .tmr_start   (tmr_start),
    .nv          (nv),
    .rwl         (rwl),
    .wl          (wl)
  );

  prot_busy_timer #(.CYCLES(NV_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .active (busy),
    .done   (tmr_done)
  );

  prot_range_decode #(
    .ADDR_W   (ADDR_W),
    .ARRAY_AW (ARRAY_AW)
  ) u_decode (
    .lock    (nv.lock),
    .wr_req  (arr_wr_req),
    .addr    (arr_addr),
    .blocked (arr_wr_block)
  );

  assign status = pack_status(nv, rwl, wl);
endmodule

// File: rtl/prot_reg_sequencer_chk.sv
`timescale 1ns/1ps
module prot_reg_sequencer_chk #(
  parameter int unsigned NV_CYCLES = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_stop,
  input logic       arr_wr_req,
  input logic       arr_wr_block,
  input logic       busy,
  input logic [7:0] status
);
  localparam int unsigned BW = $clog2(NV_CYCLES + 2);
  logic [BW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == BW'(NV_CYCLES)));

  p_busy_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < BW'(NV_CYCLES)));

  p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));

  p_one_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !($fell(status[1]) && $fell(status[2])));

  p_rwl_needs_wl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(status[1]));

  p_nv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable({status[7], status[4:3]}));

  p_block_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_block |-> arr_wr_req);

  p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6:5] == 2'b00) && !status[0]);
endmodule

bind prot_reg_sequencer prot_reg_sequencer_chk #(.NV_CYCLES(NV_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_stop     (bus_stop),
  .arr_wr_req   (arr_wr_req),
  .arr_wr_block (arr_wr_block),
  .busy         (busy),
  .status       (status)
);

// File: tb/prot_reg_sequencer_tb.sv
`timescale 1ns/1ps
module prot_reg_sequencer_tb;
  localparam int unsigned NV  = 6;
  localparam logic [15:0] RA  = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, bus_start = 1'b0, bus_stop = 1'b0, hw_lock_pin = 1'b0;
  logic        arr_wr_req = 1'b0;
  logic [15:0] reg_addr = '0, arr_addr = '0;
  logic [7:0]  reg_data = '0;
  logic        arr_wr_block, busy;
  logic [7:0]  status;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  // bench model
  logic       e_pe, e_wl, e_rwl;
  logic [1:0] e_lk;

  always #5 clk = ~clk;

  prot_reg_sequencer #(
    .ADDR_W(16), .REG_ADDR(RA), .ARRAY_AW(13), .NV_CYCLES(NV), .INIT_NV(3'b101)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
    .bus_start(bus_start), .bus_stop(bus_stop), .hw_lock_pin(hw_lock_pin),
    .arr_wr_req(arr_wr_req), .arr_addr(arr_addr), .arr_wr_block(arr_wr_block),
    .busy(busy), .status(status)
  );

  function automatic logic [7:0] exp_st();
    return {e_pe, 2'b00, e_lk, e_rwl, e_wl, 1'b0};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_data = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic ev_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic ev_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  // count busy cycles from the sample after the stop
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic commit(input logic u, input logic [1:0] lk);
    int n;
    wr(RA, 8'h02); e_wl = 1'b1;
    wr(RA, 8'h06); e_rwl = 1'b1;
    wr(RA, {u, 2'b00, lk, 3'b010});
    ev_stop();
    busy_len(n);
    e_pe = u; e_lk = lk; e_rwl = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic exp_b;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10: reset state
    e_pe = 1'b1; e_lk = 2'b01; e_wl = 1'b0; e_rwl = 1'b0;
    chk("R1 status", status, 8'h88);
    chk("R1 busy", busy, 0);
    chk("R10 layout", status, exp_st());

    // R2: wrong address has no effect
    wr(16'hFFFE, 8'h02);
    chk("R2 other addr", status, exp_st());

    // R2 / R3: sweep all data bytes from a cleared latch
    for (int d = 0; d < 256; d++) begin
      wr(RA, 8'h00);
      wr(RA, 8'(d));
      e_wl = (d[2:1] == 2'b01);
      e_rwl = 1'b0;
      chk($sformatf("R2 R3 data %02h", d), status, exp_st());
    end

    // R3: start at step 2 with write latch already set
    wr(RA, 8'h02); e_wl = 1'b1;
    wr(RA, 8'h06); e_rwl = 1'b1;
    chk("R3 rwl set", status, exp_st());

    // R5: bit2=1 and bits[2:1]=00 ignored at register-write stage
    wr(RA, 8'h9E);
    chk("R5 bit2 set", status, exp_st());
    wr(RA, 8'h00);
    chk("R5 clear ignored", status, exp_st());

    // R4: commit sweep over all retained values
    for (int v = 0; v < 8; v++) begin
      wr(RA, 8'h02); e_wl = 1'b1;
      wr(RA, 8'h06); e_rwl = 1'b1;
      wr(RA, {v[2], 2'b00, v[1:0], 3'b010});
      chk($sformatf("R4 pend %0d", v), status, exp_st());
      ev_stop();
      chk($sformatf("R4 busy rise %0d", v), busy, 1);
      repeat (2) @(negedge clk);
      chk($sformatf("R4 old nv mid-busy %0d", v), status, exp_st());
      ev_stop();
      busy_len(n);
      chk($sformatf("R4 busy length %0d", v), n + 4, NV);
      e_pe = v[2]; e_lk = v[1:0]; e_rwl = 1'b0;
      chk($sformatf("R4 new nv %0d", v), status, exp_st());
    end

    // R7: start cancels commit, stays at register-write stage
    commit(1'b0, 2'b00);
    wr(RA, 8'h06); e_rwl = 1'b1;
    wr(RA, 8'h9A);
    ev_start();
    ev_stop();
    chk("R7 no busy", busy, 0);
    repeat (NV + 2) @(negedge clk);
    chk("R7 unchanged", status, exp_st());
    wr(RA, 8'h9A);
    ev_stop();
    busy_len(n);
    e_pe = 1'b1; e_lk = 2'b11; e_rwl = 1'b0;
    chk("R7 still at step 2", status, exp_st());

    // R6: pin high and protect-enable high refuses commit
    hw_lock_pin = 1'b1;
    wr(RA, 8'h06); e_rwl = 1'b1;
    wr(RA, 8'h02);
    wr(RA, 8'h00);
    chk("R8 write ignored while refused", status, exp_st());
    ev_stop();
    chk("R6 no busy", busy, 0);
    repeat (NV + 2) @(negedge clk);
    chk("R6 unchanged", status, exp_st());
    // pin low: same stage commits
    hw_lock_pin = 1'b0;
    wr(RA, 8'h02);
    ev_stop();
    busy_len(n);
    e_pe = 1'b0; e_lk = 2'b00; e_rwl = 1'b0;
    chk("R6 pin low commits", status, exp_st());
    // pin high, protect-enable low: commit allowed
    hw_lock_pin = 1'b1;
    commit(1'b0, 2'b10);
    chk("R6 pe low commits", status, exp_st());
    hw_lock_pin = 1'b0;

    // R8: writes and bus events ignored while busy
    wr(RA, 8'h06); e_rwl = 1'b1;
    wr(RA, 8'h0A);
    ev_stop();
    wr(RA, 8'h00);
    chk("R8 write ignored busy", status, exp_st());
    @(negedge clk); bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    busy_len(n);
    e_lk = 2'b01; e_rwl = 1'b0;
    chk("R8 commit completes", status, exp_st());

    // R9: full address sweep per lock value
    for (int lk = 0; lk < 4; lk++) begin
      commit(1'b0, 2'(lk));
      arr_wr_req = 1'b1;
      bad = 0;
      for (int a = 0; a < 65536; a++) begin
        arr_addr = 16'(a);
        #1;
        exp_b = (lk == 3) || (lk == 2 && a[12]) || (lk == 1 && a[12:11] == 2'b11);
        if (arr_wr_block !== exp_b) begin
          if (bad == 0)
            $display("FAIL R9 lock %0d addr %04h actual=%0b expected=%0b", lk, a, arr_wr_block, exp_b);
          bad++;
        end
      end
      n_run++; if (bad != 0) n_fail++;
      arr_wr_req = 1'b0;
      arr_addr = 16'h1FFF;
      #1;
      chk($sformatf("R9 no req lock %0d", lk), arr_wr_block, 0);
    end

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule